// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is a bus master that turns single internal read and write requests into external bus cycles. Each cycle has three parts. The first clock drives the address, the attributes and a one-clock transfer-start strobe. The second clock is the data clock, and the controller can stretch it with wait states until a transfer acknowledge arrives. The third clock is a hold clock that keeps the address, the attributes and the write data stable. A read returns the data that was captured together with the acknowledge.

Before each cycle starts, the request address is compared against a set of chip-select windows and a pair of DRAM windows. The number of hits sets the kind of access. With no hit, the access is a plain external cycle. With one chip-select hit, that chip-select's settings apply: its port width, and either an acknowledge generated inside the block after a programmed wait count or an acknowledge from outside. With one DRAM hit, the DRAM select is driven. When several chip-selects hit, all of them are asserted together and the cycle runs burst-inhibited, on a 32-bit port, with external termination. Any hit on a DRAM window together with another window is refused with an error response, and no bus cycle is run.

Top module: `ebc_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `bus_ts`, `bus_cs`, `bus_dram_sel`, `bus_wdata_oe`, `bus_ta_drv` and `rsp_valid` are low, and `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) starts the address clock in the next cycle. In that clock `bus_ts` is high for exactly one cycle, and `bus_addr`, `bus_attr` and `bus_read` carry the request. Outside a bus cycle these outputs are zero.
- R3: On a write, `bus_wdata_oe` is high and `bus_wdata` carries the request data from the clock after the address clock through the hold clock. In every other cycle `bus_wdata_oe` is low.
- R4: On a read, `bus_rdata` is captured at the edge where the acknowledge is taken. `rsp_valid` then pulses for one cycle, in the clock after the hold clock, with that value on `rsp_rdata` and `rsp_err` low.
- R5: With external termination, the data clock repeats for as long as `bus_ta_in` is low at the clock edge. A cycle whose acknowledge comes after d wait clocks lasts 3+d clocks, counted from `bus_ts` to `rsp_valid`. `req_ready` stays low throughout.
- R6: The hold clock lasts exactly one cycle after the acknowledge. During it `bus_ts` is low, and address, attributes and write data are unchanged.
- R7: Chip-select i hits when it is enabled and `((addr[31:16] ^ base_i) & ~mask_i) == 0`, where a mask bit of 1 means "don't care". DRAM windows use the same rule. With no hit, no select is driven, `bus_psize` is 00, `bus_burst_inh` is low and termination is external.
- R8: With exactly one chip-select hit and no DRAM hit, only that chip-select is driven for the whole cycle, and `bus_psize` takes its configured code (00 = 32-bit, 01 = 8-bit, 10 = 16-bit).
- R9: A single-hit chip-select with internal acknowledge enabled raises `bus_ta_drv` on data clock number w+1, where w is its 4-bit wait count. With w = 0 the cycle takes three clocks. `bus_ta_in` is ignored for such a cycle.
- R10: With exactly one DRAM hit and no chip-select hit, only that DRAM select is driven. Termination is external and `bus_psize` is 00.
- R11: With two or more chip-select hits and no DRAM hit, every hitting chip-select is driven, `bus_burst_inh` is high, `bus_psize` is 00 and termination is external, even when a hitting chip-select has internal acknowledge enabled.
- R12: A hit on both DRAM windows, or on a DRAM window and any chip-select, starts no bus cycle. `rsp_valid` and `rsp_err` pulse together in the cycle after acceptance.
- R13: A new request is accepted in the same cycle that `rsp_valid` reports the previous one, so its address clock follows with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_attr | input | ATTR_W | Request attributes passed to the bus |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion refused because of conflicting windows |
| rsp_rdata | output | DW | Read data of the last read |
| cfg_cs_base | input | N_CS*MW | Chip-select base keys, MW bits each |
| cfg_cs_mask | input | N_CS*MW | Chip-select don't-care masks |
| cfg_cs_en | input | N_CS | Chip-select enables |
| cfg_cs_intack | input | N_CS | Internal acknowledge enables |
| cfg_cs_wait | input | N_CS*WAIT_W | Internal acknowledge wait counts |
| cfg_cs_psize | input | N_CS*2 | Port width codes |
| cfg_dr_base | input | N_DR*MW | DRAM window base keys |
| cfg_dr_mask | input | N_DR*MW | DRAM window masks |
| cfg_dr_en | input | N_DR | DRAM window enables |
| bus_addr | output | AW | Bus address |
| bus_attr | output | ATTR_W | Bus attributes |
| bus_read | output | 1 | Read cycle in progress |
| bus_ts | output | 1 | Transfer start, active high |
| bus_cs | output | N_CS | Chip-select strobes, active high |
| bus_dram_sel | output | N_DR | DRAM window selects, active high |
| bus_psize | output | 2 | Port width code of the cycle |
| bus_burst_inh | output | 1 | Burst inhibited |
| bus_wdata | output | DW | Write data |
| bus_wdata_oe | output | 1 | Write data driven |
| bus_rdata | input | DW | Read data from the bus |
| bus_ta_in | input | 1 | External transfer acknowledge, active high |
| bus_ta_drv | output | 1 | Internally generated acknowledge |

## Verification
Two events can share one cycle: the completion pulse of one transfer and the acceptance of the next. The bench queues a second request while the first is still running. It then confirms that `rsp_valid` and `req_ready` are high together, and that the next `bus_ts` follows in the very next cycle. It also sets `bus_ta_in` high at the same time as a chip-select that uses its own acknowledge, so the external and internal acknowledges collide. The cycle length must then follow the programmed wait count and not the external pin.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bus_state_e;

    typedef enum logic [2:0] {
        HIT_NONE  = 3'd0,
        HIT_CS    = 3'd1,
        HIT_DRAM  = 3'd2,
        HIT_MULTI = 3'd3,
        HIT_BAD   = 3'd4
    } hit_kind_e;

    localparam logic [1:0] PS_32 = 2'b00;
    localparam logic [1:0] PS_8  = 2'b01;
    localparam logic [1:0] PS_16 = 2'b10;

endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
    import ebc_pkg::*;
#(
    parameter int MW     = 16,
    parameter int N_CS   = 4,
    parameter int N_DR   = 2,
    parameter int WAIT_W = 4
) (
    input  logic [MW-1:0]          match_key,
    input  logic [N_CS*MW-1:0]     cs_base,
    input  logic [N_CS*MW-1:0]     cs_mask,
    input  logic [N_CS-1:0]        cs_en,
    input  logic [N_CS-1:0]        cs_intack,
    input  logic [N_CS*WAIT_W-1:0] cs_wait,
    input  logic [N_CS*2-1:0]      cs_psize,
    input  logic [N_DR*MW-1:0]     dr_base,
    input  logic [N_DR*MW-1:0]     dr_mask,
    input  logic [N_DR-1:0]        dr_en,
    output logic [N_CS-1:0]        cs_hit,
    output logic [N_DR-1:0]        dr_hit,
    output hit_kind_e              kind,
    output logic                   sel_intack,
    output logic [WAIT_W-1:0]      sel_wait,
    output logic [1:0]             sel_psize
);

    localparam int CS_CW = $clog2(N_CS + 1);
    localparam int DR_CW = $clog2(N_DR + 1);

    logic [CS_CW-1:0] cs_num;
    logic [DR_CW-1:0] dr_num;

    // one comparator per window; a set mask bit removes that key bit
    for (genvar g = 0; g < N_CS; g++) begin : g_cs_cmp
        assign cs_hit[g] = cs_en[g] &&
            (((match_key ^ cs_base[g*MW +: MW]) & ~cs_mask[g*MW +: MW]) == '0);
    end

    for (genvar g = 0; g < N_DR; g++) begin : g_dr_cmp
        assign dr_hit[g] = dr_en[g] &&
            (((match_key ^ dr_base[g*MW +: MW]) & ~dr_mask[g*MW +: MW]) == '0);
    end

    // hit counting and single-hit field selection (OR is exact for one hit)
    always_comb begin
        cs_num     = '0;
        dr_num     = '0;
        sel_intack = 1'b0;
        sel_wait   = '0;
        sel_psize  = '0;
        for (int i = 0; i < N_CS; i++) begin
            cs_num = cs_num + CS_CW'(cs_hit[i]);
            if (cs_hit[i]) begin
                sel_intack = sel_intack | cs_intack[i];
                sel_wait   = sel_wait   | cs_wait[i*WAIT_W +: WAIT_W];
                sel_psize  = sel_psize  | cs_psize[i*2 +: 2];
            end
        end
        for (int j = 0; j < N_DR; j++) begin
            dr_num = dr_num + DR_CW'(dr_hit[j]);
        end
    end

    always_comb begin
        if ((dr_num > DR_CW'(1)) || ((dr_num == DR_CW'(1)) && (cs_num != '0))) begin
            kind = HIT_BAD;
        end else if (dr_num == DR_CW'(1)) begin
            kind = HIT_DRAM;
        end else if (cs_num == '0) begin
            kind = HIT_NONE;
        end else if (cs_num == CS_CW'(1)) begin
            kind = HIT_CS;
        end else begin
            kind = HIT_MULTI;
        end
    end

endmodule

// File: rtl/ebc_waitgen.sv
module ebc_waitgen #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              en,
    input  logic [WAIT_W-1:0] limit,
    output logic              ta_int
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ta_int = en && run && (cnt_q == limit);

endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
    import ebc_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int ATTR_W = 4,
    parameter int MW     = 16,
    parameter int N_CS   = 4,
    parameter int N_DR   = 2,
    parameter int WAIT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [AW-1:0]          req_addr,
    input  logic [ATTR_W-1:0]      req_attr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [DW-1:0]          rsp_rdata,
    input  logic [N_CS*MW-1:0]     cfg_cs_base,
    input  logic [N_CS*MW-1:0]     cfg_cs_mask,
    input  logic [N_CS-1:0]        cfg_cs_en,
    input  logic [N_CS-1:0]        cfg_cs_intack,
    input  logic [N_CS*WAIT_W-1:0] cfg_cs_wait,
    input  logic [N_CS*2-1:0]      cfg_cs_psize,
    input  logic [N_DR*MW-1:0]     cfg_dr_base,
    input  logic [N_DR*MW-1:0]     cfg_dr_mask,
    input  logic [N_DR-1:0]        cfg_dr_en,
    output logic [AW-1:0]          bus_addr,
    output logic [ATTR_W-1:0]      bus_attr,
    output logic                   bus_read,
    output logic                   bus_ts,
    output logic [N_CS-1:0]        bus_cs,
    output logic [N_DR-1:0]        bus_dram_sel,
    output logic [1:0]             bus_psize,
    output logic                   bus_burst_inh,
    output logic [DW-1:0]          bus_wdata,
    output logic                   bus_wdata_oe,
    input  logic [DW-1:0]          bus_rdata,
    input  logic                   bus_ta_in,
    output logic                   bus_ta_drv
);

    typedef struct packed {
        bus_state_e        st;
        logic [AW-1:0]     addr;
        logic [ATTR_W-1:0] attr;
        logic              wr;
        logic [DW-1:0]     wdata;
        logic [N_CS-1:0]   cs;
        logic [N_DR-1:0]   dr;
        logic              int_ack;
        logic [WAIT_W-1:0] wlim;
        logic [1:0]        ps;
        logic              binh;
        logic [DW-1:0]     rdata;
        logic              rsp_v;
        logic              rsp_e;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_CS-1:0]   dec_cs;
    logic [N_DR-1:0]   dec_dr;
    hit_kind_e         dec_kind;
    logic              dec_intack;
    logic [WAIT_W-1:0] dec_wait;
    logic [1:0]        dec_psize;
    logic              ta_int;
    logic              ta_take;
    logic              active;

    ebc_decode #(
        .MW     (MW),
        .N_CS   (N_CS),
        .N_DR   (N_DR),
        .WAIT_W (WAIT_W)
    ) u_decode (
        .match_key  (req_addr[AW-1 -: MW]),
        .cs_base    (cfg_cs_base),
        .cs_mask    (cfg_cs_mask),
        .cs_en      (cfg_cs_en),
        .cs_intack  (cfg_cs_intack),
        .cs_wait    (cfg_cs_wait),
        .cs_psize   (cfg_cs_psize),
        .dr_base    (cfg_dr_base),
        .dr_mask    (cfg_dr_mask),
        .dr_en      (cfg_dr_en),
        .cs_hit     (dec_cs),
        .dr_hit     (dec_dr),
        .kind       (dec_kind),
        .sel_intack (dec_intack),
        .sel_wait   (dec_wait),
        .sel_psize  (dec_psize)
    );

    ebc_waitgen #(
        .WAIT_W (WAIT_W)
    ) u_waitgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctl_q.st == ST_ADDR),
        .run    (ctl_q.st == ST_DATA),
        .en     (ctl_q.int_ack),
        .limit  (ctl_q.wlim),
        .ta_int (ta_int)
    );

    // internal acknowledge replaces the pin entirely for its cycles
    assign ta_take = ctl_q.int_ack ? ta_int : bus_ta_in;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        ctl_d.rsp_e = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_kind == HIT_BAD) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_e = 1'b1;
                    end else begin
                        ctl_d.st      = ST_ADDR;
                        ctl_d.addr    = req_addr;
                        ctl_d.attr    = req_attr;
                        ctl_d.wr      = req_write;
                        ctl_d.wdata   = req_wdata;
                        ctl_d.cs      = dec_cs;
                        ctl_d.dr      = dec_dr;
                        ctl_d.int_ack = (dec_kind == HIT_CS) && dec_intack;
                        ctl_d.wlim    = dec_wait;
                        ctl_d.ps      = (dec_kind == HIT_CS) ? dec_psize : PS_32;
                        ctl_d.binh    = (dec_kind == HIT_MULTI);
                    end
                end
            end
            ST_ADDR: begin
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (ta_take) begin
                    ctl_d.st = ST_HOLD;
                    if (!ctl_q.wr) begin
                        ctl_d.rdata = bus_rdata;
                    end
                end
            end
            ST_HOLD: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.rsp_v = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active        = (ctl_q.st != ST_IDLE);
    assign req_ready     = !active;
    assign rsp_valid     = ctl_q.rsp_v;
    assign rsp_err       = ctl_q.rsp_e;
    assign rsp_rdata     = ctl_q.rdata;
    assign bus_ts        = (ctl_q.st == ST_ADDR);
    assign bus_addr      = active ? ctl_q.addr : '0;
    assign bus_attr      = active ? ctl_q.attr : '0;
    assign bus_read      = active && !ctl_q.wr;
    assign bus_cs        = active ? ctl_q.cs : '0;
    assign bus_dram_sel  = active ? ctl_q.dr : '0;
    assign bus_psize     = active ? ctl_q.ps : PS_32;
    assign bus_burst_inh = active && ctl_q.binh;
    assign bus_wdata_oe  = ctl_q.wr && ((ctl_q.st == ST_DATA) || (ctl_q.st == ST_HOLD));
    assign bus_wdata     = bus_wdata_oe ? ctl_q.wdata : '0;
    assign bus_ta_drv    = ta_int;

endmodule

// File: rtl/ebc_ctrl_chk.sv
module ebc_ctrl_chk #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int N_CS   = 4,
    parameter int N_DR   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_read,
    input logic            bus_ts,
    input logic [N_CS-1:0] bus_cs,
    input logic [N_DR-1:0] bus_dram_sel,
    input logic            bus_burst_inh,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_wdata_oe,
    input logic            bus_ta_drv
);

    p_ts_single_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |=> !bus_ts);

    p_ts_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |-> $past(req_valid && req_ready));

    p_wdata_only_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_oe |-> !bus_read);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ta_drv |=> (!bus_ts && $stable(bus_addr) && $stable(bus_wdata)));

    p_intack_single_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ta_drv |-> ($countones(bus_cs) == 1));

    p_inhibit_multi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst_inh |-> ($countones(bus_cs) > 1));

    p_no_dram_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dram_sel != '0 |-> ($onehot0(bus_dram_sel) && bus_cs == '0));

    p_err_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(req_valid && req_ready));

endmodule

bind ebc_ctrl ebc_ctrl_chk #(
    .AW   (AW),
    .DW   (DW),
    .N_CS (N_CS),
    .N_DR (N_DR)
) u_chk (.*);

// File: tb/ebc_ctrl_bench.sv
module ebc_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_attr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [63:0] cfg_cs_base, cfg_cs_mask;
    logic [3:0]  cfg_cs_en, cfg_cs_intack;
    logic [15:0] cfg_cs_wait;
    logic [7:0]  cfg_cs_psize;
    logic [31:0] cfg_dr_base, cfg_dr_mask;
    logic [1:0]  cfg_dr_en;
    logic [31:0] bus_addr;
    logic [3:0]  bus_attr;
    logic        bus_read, bus_ts;
    logic [3:0]  bus_cs;
    logic [1:0]  bus_dram_sel;
    logic [1:0]  bus_psize;
    logic        bus_burst_inh;
    logic [31:0] bus_wdata;
    logic        bus_wdata_oe;
    logic [31:0] bus_rdata = 32'h0;
    logic        bus_ta_in = 1'b0;
    logic        bus_ta_drv;

    // configuration held by the bench
    logic [15:0] c_base[4];
    logic [15:0] c_mask[4];
    logic        c_en[4];
    logic        c_ia[4];
    logic [3:0]  c_wait[4];
    logic [1:0]  c_ps[4];
    logic [15:0] d_base[2];
    logic [15:0] d_mask[2];
    logic        d_en[2];

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cfg_cs_base[i*16 +: 16] = c_base[i];
            cfg_cs_mask[i*16 +: 16] = c_mask[i];
            cfg_cs_en[i]            = c_en[i];
            cfg_cs_intack[i]        = c_ia[i];
            cfg_cs_wait[i*4 +: 4]   = c_wait[i];
            cfg_cs_psize[i*2 +: 2]  = c_ps[i];
        end
        for (int j = 0; j < 2; j++) begin
            cfg_dr_base[j*16 +: 16] = d_base[j];
            cfg_dr_mask[j*16 +: 16] = d_mask[j];
            cfg_dr_en[j]            = d_en[j];
        end
    end

    ebc_ctrl u_ebc_ctrl (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int fails  = 0;

    function automatic void check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0;       // 0 idle, 1 address, 2 data, 3 hold
    int          m_kind = 0;     // 0 none, 1 one cs, 2 dram, 3 several cs, 4 refused
    logic [31:0] m_addr = '0;
    logic [3:0]  m_attr = '0;
    logic        m_wr = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [3:0]  m_cs = '0;
    logic [1:0]  m_dr = '0;
    logic        m_ext = 1'b1;
    int          m_wait = 0;
    int          m_cnt = 0;
    logic [1:0]  m_ps = '0;
    logic        m_binh = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_rv = 1'b0;
    logic        m_err = 1'b0;
    logic        m_last_rd = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rv = 1'b0; m_err = 1'b0;
        end else begin
            m_rv = 1'b0; m_err = 1'b0;
            case (m_ph)
                0: if (req_valid) begin
                    int nc, nd, sel;
                    logic [3:0] hc;
                    logic [1:0] hd;
                    nc = 0; nd = 0; sel = 0;
                    for (int i = 0; i < 4; i++) begin
                        hc[i] = c_en[i] && (((req_addr[31:16] ^ c_base[i]) & ~c_mask[i]) == 16'h0);
                        if (hc[i]) begin nc++; sel = i; end
                    end
                    for (int j = 0; j < 2; j++) begin
                        hd[j] = d_en[j] && (((req_addr[31:16] ^ d_base[j]) & ~d_mask[j]) == 16'h0);
                        if (hd[j]) nd++;
                    end
                    if (nd > 1 || (nd == 1 && nc > 0)) m_kind = 4;
                    else if (nd == 1) m_kind = 2;
                    else if (nc == 0) m_kind = 0;
                    else if (nc == 1) m_kind = 1;
                    else m_kind = 3;
                    if (m_kind == 4) begin
                        m_rv = 1'b1; m_err = 1'b1;
                    end else begin
                        m_ph = 1;
                        m_addr = req_addr; m_attr = req_attr; m_wr = req_write; m_wdata = req_wdata;
                        m_cs = hc; m_dr = hd;
                        m_ext  = !(m_kind == 1 && c_ia[sel]);
                        m_wait = int'(c_wait[sel]);
                        m_ps   = (m_kind == 1) ? c_ps[sel] : 2'b00;
                        m_binh = (m_kind == 3);
                    end
                end
                1: begin m_ph = 2; m_cnt = 0; end
                2: begin
                    if (m_ext ? bus_ta_in : (m_cnt == m_wait)) begin
                        if (!m_wr) m_rdata = bus_rdata;
                        m_ph = 3;
                    end else begin
                        m_cnt++;
                    end
                end
                default: begin m_ph = 0; m_rv = 1'b1; m_last_rd = !m_wr; end
            endcase
        end
    end

    function automatic string kind_tag(int k);
        case (k)
            1: return "R8";
            2: return "R10";
            3: return "R11";
            default: return "R7";
        endcase
    endfunction

    // ---------------- per-cycle comparison, responder, monitor ----------------
    logic compare_on = 1'b0;
    int   ext_delay = 0;
    logic ta_force = 1'b0;
    int   rcnt = 0;
    int   cyc = 0;
    int   t0 = 0;
    int   last_len = 0;
    logic overlap_seen = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (compare_on) begin
            logic act;
            string kt;
            act = (m_ph != 0);
            kt  = kind_tag(m_kind);
            check("R2 bus_ts",   64'(bus_ts),   64'(m_ph == 1));
            check(m_ph == 3 ? "R6 bus_addr" : "R2 bus_addr", 64'(bus_addr), act ? 64'(m_addr) : 64'h0);
            check(m_ph == 3 ? "R6 bus_attr" : "R2 bus_attr", 64'(bus_attr), act ? 64'(m_attr) : 64'h0);
            check("R2 bus_read", 64'(bus_read), 64'(act && !m_wr));
            check("R3 bus_wdata_oe", 64'(bus_wdata_oe), 64'(m_wr && (m_ph == 2 || m_ph == 3)));
            check(m_ph == 3 ? "R6 bus_wdata" : "R3 bus_wdata", 64'(bus_wdata),
                  (m_wr && (m_ph == 2 || m_ph == 3)) ? 64'(m_wdata) : 64'h0);
            check({kt, " bus_cs"},        64'(bus_cs),        act ? 64'(m_cs) : 64'h0);
            check({kt, " bus_dram_sel"},  64'(bus_dram_sel),  act ? 64'(m_dr) : 64'h0);
            check({kt, " bus_psize"},     64'(bus_psize),     act ? 64'(m_ps) : 64'h0);
            check({kt, " bus_burst_inh"}, 64'(bus_burst_inh), 64'(act && m_binh));
            check("R9 bus_ta_drv", 64'(bus_ta_drv), 64'(m_ph == 2 && !m_ext && m_cnt == m_wait));
            check("R5 req_ready",  64'(req_ready),  64'(m_ph == 0));
            check("R4 rsp_valid",  64'(rsp_valid),  64'(m_rv));
            check("R12 rsp_err",   64'(rsp_err),    64'(m_rv && m_err));
            if (m_rv && !m_err && m_last_rd)
                check("R4 rsp_rdata", 64'(rsp_rdata), 64'(m_rdata));
        end
        if (bus_ts) t0 = cyc;
        if (rsp_valid && !rsp_err) last_len = cyc - t0;
        if (rsp_valid && req_valid && req_ready) overlap_seen = 1'b1;
        // external device: acknowledge after ext_delay data clocks
        if (m_ph == 1) begin
            rcnt = ext_delay;
            bus_ta_in = ta_force;
        end else if (m_ph == 2) begin
            bus_ta_in = ta_force || (rcnt == 0);
            if (rcnt > 0) rcnt--;
        end else begin
            bus_ta_in = ta_force;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic wr, input logic [31:0] addr, input logic [31:0] wd, input logic [3:0] at);
        logic rdy;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_attr = at;
        forever begin
            rdy = req_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_txn();
        do @(negedge clk); while (m_ph != 0 || m_rv);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            c_base[i] = '0; c_mask[i] = '0; c_en[i] = 1'b0; c_ia[i] = 1'b0; c_wait[i] = '0; c_ps[i] = '0;
        end
        for (int j = 0; j < 2; j++) begin
            d_base[j] = '0; d_mask[j] = '0; d_en[j] = 1'b0;
        end
        // cs0: internal ack, wait 0, 8-bit
        c_base[0] = 16'h1000; c_mask[0] = 16'h00FF; c_en[0] = 1; c_ia[0] = 1; c_wait[0] = 0; c_ps[0] = 2'b01;
        // cs1: internal ack, wait 3, 16-bit
        c_base[1] = 16'h2000; c_mask[1] = 16'h0000; c_en[1] = 1; c_ia[1] = 1; c_wait[1] = 3; c_ps[1] = 2'b10;
        // cs2: external ack, wide window
        c_base[2] = 16'h3000; c_mask[2] = 16'h00FF; c_en[2] = 1; c_ia[2] = 0; c_ps[2] = 2'b00;
        // cs3: internal ack wait 2, inside the cs2 window
        c_base[3] = 16'h3010; c_mask[3] = 16'h0000; c_en[3] = 1; c_ia[3] = 1; c_wait[3] = 2; c_ps[3] = 2'b01;
        d_base[0] = 16'h8000; d_mask[0] = 16'h0FFF; d_en[0] = 1;
        d_base[1] = 16'h3020; d_mask[1] = 16'h0000; d_en[1] = 1;

        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1 ts in reset",    64'(bus_ts),    64'h0);
        check("R1 ready in reset", 64'(req_ready), 64'h1);
        check("R1 rsp in reset",   64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs after reset", 64'(bus_cs),       64'h0);
        check("R1 oe after reset", 64'(bus_wdata_oe), 64'h0);
        check("R1 ta after reset", 64'(bus_ta_drv),   64'h0);
        compare_on = 1'b1;

        // R9: wait count 0 gives a three-clock write
        send(1'b1, 32'h1000_0004, 32'hCAFE_0001, 4'h3);
        finish_txn();
        check("R9 length wait0 write", 64'(last_len), 64'd3);

        // R9: external pin held high is ignored by an internally acknowledged cycle
        ta_force = 1'b1; bus_rdata = 32'h1234_5678;
        send(1'b0, 32'h2000_0010, 32'h0, 4'h5);
        finish_txn();
        ta_force = 1'b0;
        check("R9 length wait3 with pin high", 64'(last_len), 64'd6);
        check("R4 read data wait3", 64'(rsp_rdata), 64'h1234_5678);

        // R7 + R5: no window hit, external ack after two wait clocks
        ext_delay = 2; bus_rdata = 32'hA5A5_0F0F;
        send(1'b0, 32'h5000_0000, 32'h0, 4'h1);
        finish_txn();
        check("R5 length two waits", 64'(last_len), 64'd5);
        check("R4 read data plain", 64'(rsp_rdata), 64'hA5A5_0F0F);

        // R8: single cs with external ack, write, no wait
        ext_delay = 0;
        send(1'b1, 32'h3000_0010, 32'h0BAD_F00D, 4'h2);
        finish_txn();
        check("R8 length external single", 64'(last_len), 64'd3);

        // R11: two chip-selects overlap; internal ack of cs3 is not used
        ext_delay = 1; bus_rdata = 32'h0000_1111;
        send(1'b0, 32'h3010_0020, 32'h0, 4'h7);
        finish_txn();
        check("R11 length overlap external", 64'(last_len), 64'd4);

        // R10: DRAM window
        ext_delay = 1; bus_rdata = 32'h2222_3333;
        send(1'b0, 32'h8000_0100, 32'h0, 4'h0);
        finish_txn();
        check("R10 length dram", 64'(last_len), 64'd4);

        // R12: DRAM window together with a chip-select
        send(1'b0, 32'h3020_0000, 32'h0, 4'h0);
        finish_txn();
        // R12: both DRAM windows
        d_base[1] = 16'h8800; d_mask[1] = 16'h00FF;
        send(1'b1, 32'h8800_0040, 32'h5555_AAAA, 4'h0);
        finish_txn();

        // R13: back-to-back requests, completion and acceptance share a cycle
        ext_delay = 0; bus_rdata = 32'h7777_8888;
        overlap_seen = 1'b0;
        send(1'b1, 32'h1000_0000, 32'h1111_2222, 4'h4);
        send(1'b0, 32'h2000_0004, 32'h0, 4'h6);
        finish_txn();
        check("R13 overlap seen", 64'(overlap_seen), 64'h1);
        check("R13 second length", 64'(last_len), 64'd6);

        // R7: a disabled chip-select does not hit
        c_en[0] = 1'b0; ext_delay = 1;
        send(1'b1, 32'h1000_0008, 32'h9999_0000, 4'h8);
        finish_txn();
        check("R7 disabled cs length", 64'(last_len), 64'd4);

        repeat (3) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule